// File: doc/BRIEF.md
# PLL Divider Candidate Enumerator

This block searches the settings space of an integer PLL. It takes a reference frequency, limits on the internal comparison frequency and on the oscillator, and a requested oscillator window. It then walks every legal pair of pre-divider N and feedback multiplier M. For each pair it works out the comparison frequency, which is the reference divided by N, and the oscillator rate, which is 2 × M × that comparison frequency. Each pair is offered to a downstream judge over a valid/ready handshake.

The judge answers each offer with accept or reject. An accept ends the search with success and keeps the winning values. If every pair is rejected, the search ends with failure. All limits are sampled on the start pulse. The divisions are done by one shared sequential divider. A search therefore takes some tens of cycles for each N visited, plus one cycle or more for each offer.

Top module: `pll_nm_enum`

## Requirements
- R1: After reset, and whenever no search is running, `busy_o`, `cand_valid_o` and `done_o` are low.
- R2: The N range runs from nlo = max(ceil(ref / fint_max), 1) to nhi = min(floor(ref / fint_min), n_max). For each N, fint = floor(ref / N). The M range runs from max(ceil(ceil(win_min / fint) / 2), 1) to the smallest of floor(floor(win_max / fint) / 2), floor(floor(dco_max / fint) / 2) and m_max. Each offer shows N, M, fint and dco = 2·M·fint.
- R3: With `rev_i` = 0, N is the outer loop and M the inner loop. Both ascend from the low bound to the high bound, and both bounds are included.
- R4: With `rev_i` = 1, both loops descend from the high bound to the low bound, and both bounds are included.
- R5: If nlo > nhi, the search ends with `done_o` high and `found_o` low, and no offer is made.
- R6: An N whose M range is empty is skipped without any offer.
- R7: A `win_max_i` of 0 removes the window's upper limit. No offered dco exceeds `dco_max_i`.
- R8: When an offer is taken with accept high, `done_o` pulses for one cycle in the next cycle with `found_o` high. `res_*` then hold that offer's N, M, fint and dco, and no further offer is made.
- R9: If the last offer is rejected, `done_o` pulses with `found_o` low and all `res_*` equal to 0.
- R10: While `cand_valid_o` is high and `cand_ready_i` is low, the offer and all its fields stay unchanged.
- R11: A `start_i` pulse while busy is ignored, and limits that change during a search have no effect on it.
- R12: N never exceeds `n_max_i` and M never exceeds `m_max_i`, even when the frequency limits would allow more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a search, sampled when idle |
| rev_i | input | 1 | 1 = descending walk |
| ref_i | input | FW | Reference frequency |
| fint_min_i | input | FW | Minimum comparison frequency (nonzero) |
| fint_max_i | input | FW | Maximum comparison frequency (nonzero) |
| dco_max_i | input | FW | Oscillator hardware maximum |
| win_min_i | input | FW | Requested oscillator minimum |
| win_max_i | input | FW | Requested oscillator maximum, 0 = no limit |
| n_max_i | input | NW | Largest N allowed |
| m_max_i | input | MW | Largest M allowed |
| busy_o | output | 1 | Search in progress |
| cand_valid_o | output | 1 | Offer valid |
| cand_ready_i | input | 1 | Judge takes the offer |
| cand_accept_i | input | 1 | Judge's verdict, read with ready |
| cand_n_o | output | NW | Offered N |
| cand_m_o | output | MW | Offered M |
| cand_fint_o | output | FW | Offered comparison frequency |
| cand_dco_o | output | FW | Offered oscillator rate |
| done_o | output | 1 | One-cycle end-of-search pulse |
| found_o | output | 1 | Search ended with an accept |
| res_n_o | output | NW | Accepted N |
| res_m_o | output | MW | Accepted M |
| res_fint_o | output | FW | Accepted comparison frequency |
| res_dco_o | output | FW | Accepted oscillator rate |

## Verification
A bound or step that is off by one moves the very first offer, or adds or drops an offer at a range edge. That error shows on the first compared offer, or on the offer just before `done_o`. A wrong loop counter direction or last-value flag shows as an out-of-order offer, or as an offer after the expected end. A bad divider result corrupts fint or one of the M bounds, and this is visible on the first offer for the N concerned. Errors in the handshake or in the capture of results appear within one cycle of the taken offer, as a changed held offer or as wrong `res_*` values on the done pulse.

// File: rtl/pll_nm_enum_pkg.sv
package pll_nm_enum_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_NLO, ST_NHI, ST_NCHK, ST_FINT, ST_MLO,
    ST_MWIN, ST_MDCO, ST_MCHK, ST_OFFER, ST_NSTEP, ST_DONE
  } walk_st_e;
endpackage

// File: rtl/pll_div_seq.sv
module pll_div_seq #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W + 1);

  logic          run_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  quo_q, rem_q, den_q;
  logic [W:0]    sh, sub;
  logic          ge;

  always_comb begin
    sh  = {rem_q, quo_q[W-1]};
    ge  = sh >= {1'b0, den_q};
    sub = sh - {1'b0, den_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !run_q) begin
        run_q <= 1'b1;
        cnt_q <= '0;
        quo_q <= num_i;
        rem_q <= '0;
        den_q <= den_i;
      end else if (run_q) begin
        quo_q <= {quo_q[W-2:0], ge};
        rem_q <= ge ? sub[W-1:0] : sh[W-1:0];
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(W - 1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = run_q;
  assign done_o = done_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/pll_walk_ctr.sv
module pll_walk_ctr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         rev_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic [W-1:0] cur_o,
  output logic         last_o
);
  logic [W-1:0] cur_q, end_q;
  logic         rev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      end_q <= '0;
      rev_q <= 1'b0;
    end else if (load_i) begin
      cur_q <= rev_i ? hi_i : lo_i;
      end_q <= rev_i ? lo_i : hi_i;
      rev_q <= rev_i;
    end else if (step_i) begin
      cur_q <= rev_q ? cur_q - 1'b1 : cur_q + 1'b1;
    end
  end

  assign cur_o  = cur_q;
  assign last_o = cur_q == end_q;
endmodule

// File: rtl/pll_nm_enum.sv
module pll_nm_enum
  import pll_nm_enum_pkg::*;
#(
  parameter int FW = 32,
  parameter int NW = 8,
  parameter int MW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rev_i,
  input  logic [FW-1:0] ref_i,
  input  logic [FW-1:0] fint_min_i,
  input  logic [FW-1:0] fint_max_i,
  input  logic [FW-1:0] dco_max_i,
  input  logic [FW-1:0] win_min_i,
  input  logic [FW-1:0] win_max_i,
  input  logic [NW-1:0] n_max_i,
  input  logic [MW-1:0] m_max_i,
  output logic          busy_o,
  output logic          cand_valid_o,
  input  logic          cand_ready_i,
  input  logic          cand_accept_i,
  output logic [NW-1:0] cand_n_o,
  output logic [MW-1:0] cand_m_o,
  output logic [FW-1:0] cand_fint_o,
  output logic [FW-1:0] cand_dco_o,
  output logic          done_o,
  output logic          found_o,
  output logic [NW-1:0] res_n_o,
  output logic [MW-1:0] res_m_o,
  output logic [FW-1:0] res_fint_o,
  output logic [FW-1:0] res_dco_o
);
  localparam int PW = FW + MW + 1;

  walk_st_e st_q;

  logic [FW-1:0] cfg_ref_q, cfg_fmin_q, cfg_fmax_q, cfg_dco_max_q;
  logic [FW-1:0] cfg_wmin_q, cfg_wmax_q;
  logic [NW-1:0] cfg_nmax_q;
  logic [MW-1:0] cfg_mmax_q;
  logic          cfg_rev_q;

  logic [FW-1:0] nlo_q, nhi_q, fint_q, mlo_q, mwin_q, mhi_q;
  logic          found_q, issued_q;
  logic [NW-1:0] res_n_q;
  logic [MW-1:0] res_m_q;
  logic [FW-1:0] res_fint_q, res_dco_q;

  logic          div_start, div_busy, div_done, in_div;
  logic [FW-1:0] div_num, div_den, div_quo, div_rem, q_ceil;
  logic [FW:0]   ceil_half;
  logic [FW-1:0] mlo_nxt, mhi_nxt, mdco_half;

  logic          n_load, n_step, n_last, m_load, m_step, m_last;
  logic [NW-1:0] n_cur;
  logic [MW-1:0] m_cur;
  logic [PW-1:0] dco_full;
  logic          take, n_empty, m_empty;

  // divider operand select
  always_comb begin
    div_num = cfg_ref_q;
    div_den = cfg_fmax_q;
    in_div  = 1'b0;
    unique case (st_q)
      ST_NLO:  in_div = 1'b1;
      ST_NHI:  begin in_div = 1'b1; div_den = cfg_fmin_q; end
      ST_FINT: begin in_div = 1'b1; div_den = FW'(n_cur); end
      ST_MLO:  begin in_div = 1'b1; div_num = cfg_wmin_q; div_den = fint_q; end
      ST_MWIN: begin in_div = cfg_wmax_q != '0; div_num = cfg_wmax_q; div_den = fint_q; end
      ST_MDCO: begin in_div = 1'b1; div_num = cfg_dco_max_q; div_den = fint_q; end
      default: ;
    endcase
  end

  assign div_start = in_div && !issued_q && !div_busy;

  pll_div_seq #(.W(FW)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_start),
    .num_i  (div_num),
    .den_i  (div_den),
    .busy_o (div_busy),
    .done_o (div_done),
    .quo_o  (div_quo),
    .rem_o  (div_rem)
  );

  // bound arithmetic
  always_comb begin
    q_ceil    = div_quo + FW'(div_rem != '0);
    ceil_half = ({1'b0, q_ceil} + 1'b1) >> 1;
    mlo_nxt   = (ceil_half == '0) ? FW'(1) : ceil_half[FW-1:0];
    mdco_half = div_quo >> 1;
    mhi_nxt   = (mwin_q < mdco_half) ? mwin_q : mdco_half;
    if (FW'(cfg_mmax_q) < mhi_nxt) mhi_nxt = FW'(cfg_mmax_q);
  end

  assign n_empty = nlo_q > nhi_q;
  assign m_empty = mlo_q > mhi_q;
  assign take    = (st_q == ST_OFFER) && cand_ready_i;
  assign n_load  = (st_q == ST_NCHK) && !n_empty;
  assign n_step  = (st_q == ST_NSTEP) && !n_last;
  assign m_load  = (st_q == ST_MCHK) && !m_empty;
  assign m_step  = take && !cand_accept_i && !m_last;

  pll_walk_ctr #(.W(NW)) u_nctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(n_load),
    .step_i(n_step),
    .rev_i (cfg_rev_q),
    .lo_i  (nlo_q[NW-1:0]),
    .hi_i  (nhi_q[NW-1:0]),
    .cur_o (n_cur),
    .last_o(n_last)
  );

  pll_walk_ctr #(.W(MW)) u_mctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(m_load),
    .step_i(m_step),
    .rev_i (cfg_rev_q),
    .lo_i  (mlo_q[MW-1:0]),
    .hi_i  (mhi_q[MW-1:0]),
    .cur_o (m_cur),
    .last_o(m_last)
  );

  assign dco_full = ({{(PW-FW){1'b0}}, fint_q} * {{(PW-MW){1'b0}}, m_cur}) << 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      cfg_ref_q     <= '0;
      cfg_fmin_q    <= '0;
      cfg_fmax_q    <= '0;
      cfg_dco_max_q <= '0;
      cfg_wmin_q    <= '0;
      cfg_wmax_q    <= '0;
      cfg_nmax_q    <= '0;
      cfg_mmax_q    <= '0;
      cfg_rev_q     <= 1'b0;
      nlo_q         <= '0;
      nhi_q         <= '0;
      fint_q        <= '0;
      mlo_q         <= '0;
      mwin_q        <= '0;
      mhi_q         <= '0;
      issued_q      <= 1'b0;
      found_q       <= 1'b0;
      res_n_q       <= '0;
      res_m_q       <= '0;
      res_fint_q    <= '0;
      res_dco_q     <= '0;
    end else begin
      if (div_start) issued_q <= 1'b1;
      if (div_done)  issued_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          cfg_ref_q     <= ref_i;
          cfg_fmin_q    <= fint_min_i;
          cfg_fmax_q    <= fint_max_i;
          cfg_dco_max_q <= dco_max_i;
          cfg_wmin_q    <= win_min_i;
          cfg_wmax_q    <= win_max_i;
          cfg_nmax_q    <= n_max_i;
          cfg_mmax_q    <= m_max_i;
          cfg_rev_q     <= rev_i;
          found_q       <= 1'b0;
          res_n_q       <= '0;
          res_m_q       <= '0;
          res_fint_q    <= '0;
          res_dco_q     <= '0;
          st_q          <= ST_NLO;
        end
        ST_NLO: if (div_done) begin
          nlo_q <= (q_ceil == '0) ? FW'(1) : q_ceil;
          st_q  <= ST_NHI;
        end
        ST_NHI: if (div_done) begin
          nhi_q <= (div_quo > FW'(cfg_nmax_q)) ? FW'(cfg_nmax_q) : div_quo;
          st_q  <= ST_NCHK;
        end
        ST_NCHK: st_q <= n_empty ? ST_DONE : ST_FINT;
        ST_FINT: if (div_done) begin
          fint_q <= div_quo;
          st_q   <= ST_MLO;
        end
        ST_MLO: if (div_done) begin
          mlo_q <= mlo_nxt;
          st_q  <= ST_MWIN;
        end
        ST_MWIN: begin
          if (cfg_wmax_q == '0) begin
            mwin_q <= '1;
            st_q   <= ST_MDCO;
          end else if (div_done) begin
            mwin_q <= div_quo >> 1;
            st_q   <= ST_MDCO;
          end
        end
        ST_MDCO: if (div_done) begin
          mhi_q <= mhi_nxt;
          st_q  <= ST_MCHK;
        end
        ST_MCHK: st_q <= m_empty ? ST_NSTEP : ST_OFFER;
        ST_OFFER: if (take) begin
          if (cand_accept_i) begin
            found_q    <= 1'b1;
            res_n_q    <= n_cur;
            res_m_q    <= m_cur;
            res_fint_q <= fint_q;
            res_dco_q  <= dco_full[FW-1:0];
            st_q       <= ST_DONE;
          end else if (m_last) begin
            st_q <= ST_NSTEP;
          end
        end
        ST_NSTEP: st_q <= n_last ? ST_DONE : ST_FINT;
        ST_DONE:  st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = st_q != ST_IDLE;
  assign cand_valid_o = st_q == ST_OFFER;
  assign cand_n_o     = n_cur;
  assign cand_m_o     = m_cur;
  assign cand_fint_o  = fint_q;
  assign cand_dco_o   = dco_full[FW-1:0];
  assign done_o       = st_q == ST_DONE;
  assign found_o      = found_q;
  assign res_n_o      = res_n_q;
  assign res_m_o      = res_m_q;
  assign res_fint_o   = res_fint_q;
  assign res_dco_o    = res_dco_q;
endmodule

// File: rtl/pll_nm_enum_chk.sv
module pll_nm_enum_chk #(
  parameter int FW = 32,
  parameter int NW = 8,
  parameter int MW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          cand_valid_o,
  input logic          cand_ready_i,
  input logic          cand_accept_i,
  input logic [NW-1:0] cand_n_o,
  input logic [MW-1:0] cand_m_o,
  input logic [FW-1:0] cand_dco_o,
  input logic          done_o,
  input logic          found_o,
  input logic [NW-1:0] res_n_o,
  input logic [MW-1:0] res_m_o,
  input logic [FW-1:0] dco_cap_i
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!cand_valid_o && !done_o));

  p_offer_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_valid_o && !cand_ready_i) |=>
      (cand_valid_o && $stable(cand_n_o) && $stable(cand_m_o) && $stable(cand_dco_o)));

  p_accept_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_valid_o && cand_ready_i && cand_accept_i) |=> (done_o && found_o));

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_result_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_valid_o && cand_ready_i && cand_accept_i) |=>
      (res_n_o == $past(cand_n_o) && res_m_o == $past(cand_m_o)));

  p_miss_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !found_o) |-> (res_n_o == '0 && res_m_o == '0));

  p_dco_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_valid_o |-> (cand_dco_o <= dco_cap_i && cand_m_o != '0 && cand_n_o != '0));
endmodule

bind pll_nm_enum pll_nm_enum_chk #(.FW(FW), .NW(NW), .MW(MW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .cand_valid_o (cand_valid_o),
  .cand_ready_i (cand_ready_i),
  .cand_accept_i(cand_accept_i),
  .cand_n_o     (cand_n_o),
  .cand_m_o     (cand_m_o),
  .cand_dco_o   (cand_dco_o),
  .done_o       (done_o),
  .found_o      (found_o),
  .res_n_o      (res_n_o),
  .res_m_o      (res_m_o),
  .dco_cap_i    (cfg_dco_max_q)
);

// File: tb/sim_pll_nm_enum.sv
`timescale 1ns/1ps
module sim_pll_nm_enum;
  localparam int FW = 32;
  localparam int NW = 8;
  localparam int MW = 12;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, rev_i = 1'b0;
  logic [FW-1:0] ref_i = '0, fint_min_i = '0, fint_max_i = '0, dco_max_i = '0;
  logic [FW-1:0] win_min_i = '0, win_max_i = '0;
  logic [NW-1:0] n_max_i = '0;
  logic [MW-1:0] m_max_i = '0;
  logic cand_ready_i = 1'b0, cand_accept_i = 1'b0;
  logic busy_o, cand_valid_o, done_o, found_o;
  logic [NW-1:0] cand_n_o, res_n_o;
  logic [MW-1:0] cand_m_o, res_m_o;
  logic [FW-1:0] cand_fint_o, cand_dco_o, res_fint_o, res_dco_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  pll_nm_enum #(.FW(FW), .NW(NW), .MW(MW)) u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic run_case(input string req, input longint rf, input longint fmn,
                          input longint fmx, input longint dmx, input longint wmn,
                          input longint wmx, input longint nmx, input longint mmx,
                          input bit rev, input int acc_idx, input int hold,
                          input bit poke);
    longint nlo, nhi, fint, c, mlo, mhi, n, m, en, em, ef, ed;
    int idx = 0;
    bit stop = 1'b0;
    bit exp_found = 1'b0;
    int t;
    @(negedge clk_i);
    ref_i = FW'(rf); fint_min_i = FW'(fmn); fint_max_i = FW'(fmx);
    dco_max_i = FW'(dmx); win_min_i = FW'(wmn); win_max_i = FW'(wmx);
    n_max_i = NW'(nmx); m_max_i = MW'(mmx); rev_i = rev; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke) begin
      // R11: restart attempt with different limits while busy
      repeat (3) @(negedge clk_i);
      ref_i = FW'(rf + 77); win_min_i = '0; rev_i = ~rev; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    en = 0; em = 0; ef = 0; ed = 0;
    nlo = (rf + fmx - 1) / fmx;
    if (nlo < 1) nlo = 1;
    nhi = rf / fmn;
    if (nhi > nmx) nhi = nmx;
    if (nlo <= nhi) begin
      for (longint k = 0; k <= nhi - nlo; k++) begin
        if (stop) break;
        n = rev ? nhi - k : nlo + k;
        fint = rf / n;
        c = (wmn + fint - 1) / fint;
        mlo = (c + 1) / 2;
        if (mlo < 1) mlo = 1;
        mhi = dmx / fint / 2;
        if (wmx != 0 && wmx / fint / 2 < mhi) mhi = wmx / fint / 2;
        if (mmx < mhi) mhi = mmx;
        if (mlo > mhi) continue;  // R6 skipped N
        for (longint j = 0; j <= mhi - mlo; j++) begin
          m = rev ? mhi - j : mlo + j;
          t = 0;
          while (!cand_valid_o && !done_o && t < 5000) begin
            @(negedge clk_i);
            t++;
          end
          chk(cand_valid_o, req, "offer present", longint'(cand_valid_o), 1);
          if (!cand_valid_o) return;
          chk(cand_n_o == NW'(n), req, (idx == 0) ? "R2 first N" : "N order", cand_n_o, n);
          chk(cand_m_o == MW'(m), req, (idx == 0) ? "R2 first M" : "M order", cand_m_o, m);
          chk(cand_fint_o == FW'(fint), req, "R2 fint", cand_fint_o, fint);
          chk(cand_dco_o == FW'(2 * m * fint), req, "R2 dco", cand_dco_o, 2 * m * fint);
          for (int h = 0; h < hold; h++) begin
            @(negedge clk_i);
            chk(cand_valid_o && cand_n_o == NW'(n) && cand_m_o == MW'(m),
                "R10", "held offer", cand_m_o, m);
          end
          cand_accept_i = (idx == acc_idx);
          cand_ready_i = 1'b1;
          @(negedge clk_i);
          cand_ready_i = 1'b0;
          cand_accept_i = 1'b0;
          if (idx == acc_idx) begin
            stop = 1'b1; exp_found = 1'b1;
            en = n; em = m; ef = fint; ed = 2 * m * fint;
            break;
          end
          idx++;
        end
      end
    end
    ref_i = FW'(rf); win_min_i = FW'(wmn); rev_i = rev;
    t = 0;
    while (!done_o && !cand_valid_o && t < 8000) begin
      @(negedge clk_i);
      t++;
    end
    chk(done_o && !cand_valid_o, req, "end of search without extra offer",
        longint'(cand_valid_o), 0);
    chk(found_o == exp_found, exp_found ? "R8" : "R9", "found flag", found_o, exp_found);
    chk(res_n_o == NW'(en) && res_m_o == MW'(em), exp_found ? "R8" : "R9",
        "result N/M", {res_n_o, res_m_o}, {en[NW-1:0], em[MW-1:0]});
    chk(res_fint_o == FW'(ef) && res_dco_o == FW'(ed), exp_found ? "R8" : "R9",
        "result fint/dco", res_dco_o, ed);
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R1", "idle after done", longint'(busy_o), 0);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !cand_valid_o && !done_o, "R1", "reset outputs", longint'(busy_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !cand_valid_o, "R1", "idle after reset", longint'(cand_valid_o), 0);
    // R3 R7 R9 R11: ascending, open window, reject all, restart poke
    run_case("R3", 1000, 100, 400, 3000, 1200, 0, 15, 20, 1'b0, -1, 0, 1'b1);
    // R8 R10: accept sixth offer with a held offer
    run_case("R8", 1000, 100, 400, 3000, 1200, 0, 15, 20, 1'b0, 5, 3, 1'b0);
    // R4: descending, reject all
    run_case("R4", 1000, 100, 400, 3000, 1200, 0, 15, 20, 1'b1, -1, 0, 1'b0);
    // R5: empty N range
    run_case("R5", 1000, 600, 700, 3000, 1200, 0, 15, 20, 1'b0, -1, 0, 1'b0);
    // R6: narrow window leaves some N with no M
    run_case("R6", 1000, 100, 1000, 5000, 1000, 1100, 20, 50, 1'b0, -1, 0, 1'b0);
    // R12: clipped N and M, descending with accept
    run_case("R12", 1000, 100, 400, 3000, 600, 0, 5, 3, 1'b1, 2, 0, 1'b0);
    report();
  end
endmodule